// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Control Unit

This block handles hardware handshaking for one UART channel. On the receive side it compares the receive FIFO fill count with a programmed trigger level. It raises a receive interrupt when the fill reaches that level. It also drives the active-low request-to-send output with hysteresis. Two thresholds are built from the trigger and a hysteresis amount: an upper one that throttles the far end, and a lower one that releases it again. When automatic RTS is off, the pin simply follows the software RTS control bit and serves as a general-purpose output.

On the transmit side the active-low clear-to-send input passes through a two-flop synchronizer and gates the transmitter. A stop request is taken only at a character boundary, which the transmitter marks with a one-cycle "character done" strobe, so a frame is never cut short. Once stopped, the unit lets transmission resume as soon as the synchronized clear-to-send is low again, with no boundary needed. When automatic CTS is off, transmission is always permitted.

Top module: `uart_flow_ctl`

## Requirements
- R1: While rst_n is low, rts_n is 1, tx_permit is 1 and rx_irq is 0, and the hysteresis state reads as not throttled.
- R2: With auto_rts_en high, rx_irq is 1 in the cycle after an edge that saw rx_fill >= trig_lvl, and 0 after an edge that saw rx_fill < trig_lvl. With auto_rts_en low, rx_irq is 0 after the next edge.
- R3: The upper threshold is min(trig_lvl + hyst_lvl, DEPTH) and the lower threshold is max(trig_lvl - hyst_lvl, 0). Both saturate without wrapping.
- R4: With auto_rts_en and sw_rts high, rts_n is 1 after an edge that saw rx_fill >= upper threshold.
- R5: Once throttled, rts_n stays 1 while rx_fill stays at or above the lower threshold. It returns to 0 after the first edge that sees rx_fill below the lower threshold.
- R6: With sw_rts low, rts_n is 1 after the next edge, whatever the fill level and enables.
- R7: With auto_rts_en low, rts_n equals the inverse of sw_rts one cycle later, and the throttled state is cleared. On re-enable with the fill between the thresholds, rts_n is 0.
- R8: With auto_cts_en high, cts_n is synchronized through two flops. tx_permit falls only right after an edge where tx_char_done is 1 and the synchronized cts_n is 1. A high cts_n with no boundary strobe, or one that is already gone by the boundary, leaves tx_permit at 1.
- R9: While stopped, tx_permit returns to 1 after the third rising edge following cts_n going low, with no tx_char_done required.
- R10: With auto_cts_en low, tx_permit is 1 regardless of cts_n and tx_char_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_rts_en | input | 1 | Automatic RTS enable (feature register bit 6) |
| auto_cts_en | input | 1 | Automatic CTS enable (feature register bit 7) |
| sw_rts | input | 1 | Software RTS control; 1 requests rts_n low |
| rx_fill | input | CW | Receive FIFO fill count, 0..DEPTH |
| trig_lvl | input | CW | Receive trigger level |
| hyst_lvl | input | CW | Hysteresis amount around the trigger |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| tx_char_done | input | 1 | One-cycle strobe at each character boundary |
| rts_n | output | 1 | Active-low request-to-send |
| tx_permit | output | 1 | 1 lets the transmitter start a character |
| rx_irq | output | 1 | Receive trigger-level interrupt |

## Verification
The bench builds the unit with DEPTH = 16, which gives a five-bit count. With that depth, trigger plus hysteresis can exceed the FIFO depth (14 + 4), so the saturation of the upper threshold is exercised, and a small trigger with larger hysteresis (2 - 4) reaches the clamp of the lower threshold at zero. A behavioural model with a queue standing in for the synchronizer predicts all three outputs on every clock. Directed steps also cover hysteresis bands entered from above and below, a clear-to-send glitch that ends before the boundary, and disabling each feature mid-throttle.

// File: rtl/uart_flow_ctl.sv
`timescale 1ns/1ps
module uart_flow_ctl #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_rts_en,
  input  logic          auto_cts_en,
  input  logic          sw_rts,
  input  logic [CW-1:0] rx_fill,
  input  logic [CW-1:0] trig_lvl,
  input  logic [CW-1:0] hyst_lvl,
  input  logic          cts_n,
  input  logic          tx_char_done,
  output logic          rts_n,
  output logic          tx_permit,
  output logic          rx_irq
);
  localparam int SW = CW + 1;

  logic [SW-1:0] sum_w;
  logic [CW-1:0] upper_lvl, lower_lvl;
  logic          thr_q, thr_nxt;
  logic [1:0]    cts_s;
  logic          stop_q;

  // R3: saturating thresholds
  assign sum_w     = {1'b0, trig_lvl} + {1'b0, hyst_lvl};
  assign upper_lvl = (sum_w > SW'(DEPTH)) ? CW'(DEPTH) : sum_w[CW-1:0];
  assign lower_lvl = (hyst_lvl > trig_lvl) ? '0 : trig_lvl - hyst_lvl;

  always_comb begin
    thr_nxt = thr_q;
    if (!auto_rts_en)               thr_nxt = 1'b0;
    else if (rx_fill >= upper_lvl)  thr_nxt = 1'b1;
    else if (rx_fill <  lower_lvl)  thr_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= 1'b0;
      rts_n  <= 1'b1;
      rx_irq <= 1'b0;
    end else begin
      thr_q  <= thr_nxt;
      rts_n  <= ~sw_rts | (auto_rts_en & thr_nxt);
      rx_irq <= auto_rts_en & (rx_fill >= trig_lvl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s  <= 2'b11;
      stop_q <= 1'b0;
    end else begin
      cts_s <= {cts_s[0], cts_n};
      if (!auto_cts_en)                stop_q <= 1'b0;
      else if (stop_q || tx_char_done) stop_q <= cts_s[1];
    end
  end

  assign tx_permit = ~auto_cts_en | ~stop_q;

  a_r2_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_fill >= trig_lvl) |=> rx_irq);
  a_r2_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> !rx_irq);
  a_r4_throttle_at_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && sw_rts && rx_fill >= upper_lvl) |=> rts_n);
  a_r5_release_below_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && sw_rts && rx_fill < lower_lvl && rx_fill < upper_lvl) |=> !rts_n);
  a_r6_sw_deassert: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rts |=> rts_n);
  a_r7_plain_output: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(sw_rts)));
  a_r8_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_permit) |-> ($past(tx_char_done) && $past(auto_cts_en)));
  a_r9_resume_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_permit) && $past(auto_cts_en) && auto_cts_en) |-> !$past(cts_s[1]));
endmodule

// File: tb/uart_flow_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_flow_ctl_tb_top;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_rts_en = 1'b0, auto_cts_en = 1'b0, sw_rts = 1'b0;
  logic [CW-1:0] rx_fill = '0, trig_lvl = '0, hyst_lvl = '0;
  logic cts_n = 1'b1, tx_char_done = 1'b0;
  logic rts_n, tx_permit, rx_irq;

  int nchk = 0, nbad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_flow_ctl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .sw_rts(sw_rts), .rx_fill(rx_fill), .trig_lvl(trig_lvl), .hyst_lvl(hyst_lvl),
    .cts_n(cts_n), .tx_char_done(tx_char_done),
    .rts_n(rts_n), .tx_permit(tx_permit), .rx_irq(rx_irq));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_thr = 0, m_rts = 1, m_irq = 0, m_stop = 0;
  int cq[$] = '{1, 1};
  always @(posedge clk) begin
    if (!rst_n) begin
      m_thr = 0; m_rts = 1; m_irq = 0; m_stop = 0;
      cq = '{1, 1};
    end else begin
      int up, lo, s2;
      up = int'(trig_lvl) + int'(hyst_lvl);
      if (up > DEPTH) up = DEPTH;
      lo = int'(trig_lvl) - int'(hyst_lvl);
      if (lo < 0) lo = 0;
      if (!auto_rts_en) m_thr = 0;
      else if (int'(rx_fill) >= up) m_thr = 1;
      else if (int'(rx_fill) < lo) m_thr = 0;
      m_rts = (!sw_rts || (auto_rts_en && m_thr == 1)) ? 1 : 0;
      m_irq = (auto_rts_en && rx_fill >= trig_lvl) ? 1 : 0;
      s2 = cq[0];
      if (!auto_cts_en) m_stop = 0;
      else if (m_stop == 1 || tx_char_done) m_stop = s2;
      void'(cq.pop_front());
      cq.push_back(int'(cts_n));
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 R5 R6 R7 rts_n model", int'(rts_n), m_rts);
      chk("R2 rx_irq model", int'(rx_irq), m_irq);
      chk("R8 R9 R10 tx_permit model", int'(tx_permit), (!auto_cts_en || m_stop == 0) ? 1 : 0);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic put(int v);
    rx_fill = CW'(v); tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      nchk++; nbad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 rts_n reset", int'(rts_n), 1);
    chk("R1 tx_permit reset", int'(tx_permit), 1);
    chk("R1 rx_irq reset", int'(rx_irq), 0);
    rst_n = 1'b1;
    // R7 plain output
    sw_rts = 1; tick(); chk("R7 gpo low", int'(rts_n), 0);
    sw_rts = 0; tick(); chk("R6 gpo high", int'(rts_n), 1);
    sw_rts = 1; tick();
    // auto RTS: trig 8, hyst 3 -> upper 11, lower 5
    auto_rts_en = 1; trig_lvl = 8; hyst_lvl = 3;
    put(7);  chk("R2 below trig", int'(rx_irq), 0); chk("R4 below upper", int'(rts_n), 0);
    put(8);  chk("R2 at trig", int'(rx_irq), 1);
    put(10); chk("R4 just under upper", int'(rts_n), 0);
    put(11); chk("R4 at upper", int'(rts_n), 1);
    put(16); chk("R4 full", int'(rts_n), 1);
    put(7);  chk("R2 cleared", int'(rx_irq), 0); chk("R5 hold band", int'(rts_n), 1);
    put(5);  chk("R5 at lower", int'(rts_n), 1);
    put(4);  chk("R5 released", int'(rts_n), 0);
    put(10); chk("R5 band from below", int'(rts_n), 0);
    // R6 software deassert overrides
    put(12); chk("R4 again", int'(rts_n), 1);
    sw_rts = 0; put(2); chk("R6 sw off", int'(rts_n), 1);
    sw_rts = 1; tick(); chk("R5 sw back low fill", int'(rts_n), 0);
    sw_rts = 0; put(0); chk("R6 sw off empty", int'(rts_n), 1);
    sw_rts = 1;
    // R7 disable clears throttle
    put(12); chk("R4 throttle", int'(rts_n), 1);
    auto_rts_en = 0; tick(); chk("R7 disabled", int'(rts_n), 0); chk("R2 off", int'(rx_irq), 0);
    rx_fill = 8; auto_rts_en = 1; tick(); chk("R7 state cleared", int'(rts_n), 0);
    // R3 upper saturation: 14+4 -> 16, lower 10
    trig_lvl = 14; hyst_lvl = 4;
    put(15); chk("R3 sat upper not reached", int'(rts_n), 0);
    put(16); chk("R3 sat upper reached", int'(rts_n), 1);
    put(10); chk("R3 lower hold", int'(rts_n), 1);
    put(9);  chk("R3 lower release", int'(rts_n), 0);
    // R3 lower clamp: 2-4 -> 0, upper 6
    trig_lvl = 2; hyst_lvl = 4;
    put(6); chk("R3 clamp throttle", int'(rts_n), 1);
    put(0); chk("R3 clamp no release", int'(rts_n), 1);
    auto_rts_en = 0; tick(); auto_rts_en = 1;
    // zero hysteresis
    trig_lvl = 5; hyst_lvl = 0;
    put(5); chk("R3 zero hyst set", int'(rts_n), 1);
    put(4); chk("R3 zero hyst clear", int'(rts_n), 0);
    // CTS
    auto_cts_en = 1; cts_n = 1;
    repeat (4) tick();
    chk("R8 no boundary", int'(tx_permit), 1);
    tx_char_done = 1; tick(); tx_char_done = 0;
    chk("R8 stop at boundary", int'(tx_permit), 0);
    cts_n = 0; tick(); chk("R9 sync1", int'(tx_permit), 0);
    tick(); chk("R9 sync2", int'(tx_permit), 0);
    tick(); chk("R9 resumed", int'(tx_permit), 1);
    cts_n = 1; tick(); cts_n = 0; tx_char_done = 1; tick(); tx_char_done = 0;
    chk("R8 glitch before boundary", int'(tx_permit), 1);
    repeat (3) tick();
    chk("R8 glitch gone", int'(tx_permit), 1);
    // R10
    cts_n = 1; repeat (3) tick();
    tx_char_done = 1; tick(); tx_char_done = 0;
    chk("R8 stopped again", int'(tx_permit), 0);
    auto_cts_en = 0; tick(); chk("R10 disabled", int'(tx_permit), 1);
    tx_char_done = 1; tick(); tx_char_done = 0;
    chk("R10 boundary ignored", int'(tx_permit), 1);
    repeat (3) tick();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule